// File: doc/BRIEF.md
# Scaled-Operand Add Datapath

This block is the add stage of a single-cycle integer execute unit. One of the two adder inputs passes through a small left shifter that moves its operand up by zero to three bit positions. The same shifter does two jobs. For arithmetic, it gives a shift-then-add operation that software can chain to build integer multiplication. For memory addressing, it scales an index register so that an index counts halfwords, words or doublewords instead of bytes. Every register value routed to the shifted input goes through the shifter. Operations that need no scaling force the shift amount to zero.

An immediate field is sign-extended in parallel with the shift. It replaces the shifted operand when the operation calls for it. A single adder produces either the arithmetic result or the effective address. AND and OR bypass the shifter. Outputs are registered on the rising clock edge, one cycle after the inputs are presented.

Opcode encoding on `op_i`:
- 000: shift-and-add
- 001: add immediate
- 010: AND
- 011: OR
- 100: indexed address
- 101: immediate-offset address
- 110 and 111: perform nothing

Top module: `ps_exec_top`

## Requirements
- R1: With opcode 000, result_o becomes rs1_i + (rs2_i shifted left by shamt_i), modulo 2^32. Bits shifted past bit 31 are dropped and the vacated low bits are zero.
- R2: carry_o is registered with result_o and holds the carry out of bit 31 of the 32-bit addition. For AND and OR it is 0.
- R3: The shift range is 0 to 3 (shamt_i is 2 bits wide). Opcode 000 with shamt_i = 0 yields the plain sum rs1_i + rs2_i.
- R4: With opcode 100, addr_o becomes rs1_i + (rs2_i << k), modulo 2^32. scale_i selects k: 00 gives k=0 (byte), 01 gives k=1 (halfword), 10 gives k=2 (word), 11 gives k=3 (doubleword).
- R5: With opcode 101, addr_o becomes rs1_i + sign-extended imm_i[15:0]. scale_i and rs2_i have no effect on it.
- R6: With opcode 010, result_o becomes rs1_i & rs2_i. With opcode 011, it becomes rs1_i | rs2_i. In both cases rs2_i is taken unshifted whatever shamt_i holds.
- R7: With opcode 001, result_o becomes rs1_i + sign-extended imm_i, and carry_o is the carry of that 32-bit sum. shamt_i has no effect.
- R8: Opcodes 000 to 011 leave addr_o unchanged. Opcodes 100 and 101 leave result_o and carry_o unchanged. Opcodes 110 and 111 leave all three outputs unchanged.
- R9: A synchronous active-high rst clears result_o, carry_o and addr_o to zero at the next rising edge.
- R10: Each operation's outputs appear at the first rising edge after its inputs are applied. Back-to-back operations therefore update on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code (encoding above) |
| rs1_i | input | 32 | Unshifted operand, also the address base |
| rs2_i | input | 32 | Operand routed through the pre-shifter |
| imm_i | input | 16 | Immediate field, sign-extended |
| shamt_i | input | 2 | Shift amount used by opcode 000 |
| scale_i | input | 2 | Index scale code used by opcode 100 |
| result_o | output | 32 | Registered arithmetic or logic result |
| carry_o | output | 1 | Registered carry out of the result addition |
| addr_o | output | 32 | Registered effective address |

## Verification
Every output is due at the first rising edge after its inputs are driven. Inputs are therefore applied on the falling edge. For each operation, the expected result, carry and address go into a queue at that moment. A monitor wakes 1 ns after each rising edge, pops exactly one queued entry and compares all three outputs against it. This keeps the one-cycle latency of R10 locked in for every check, including back-to-back operations and resets. The expected hold values come from a model state kept in the bench, so R8 is checked at the outputs on the very cycle after each non-writing operation.

// File: rtl/ps_pkg.sv
package ps_pkg;

    typedef enum logic [2:0] {
        OP_SHADD = 3'b000,
        OP_ADDI  = 3'b001,
        OP_AND   = 3'b010,
        OP_OR    = 3'b011,
        OP_LDX   = 3'b100,
        OP_LDI   = 3'b101,
        OP_NOP6  = 3'b110,
        OP_NOP7  = 3'b111
    } op_e;

    typedef enum logic [1:0] {
        RS_SUM = 2'b00,
        RS_AND = 2'b01,
        RS_OR  = 2'b10
    } res_sel_e;

endpackage

// File: rtl/ps_decode.sv
module ps_decode
    import ps_pkg::*;
#(
    parameter int SHW = 2
) (
    input  logic [2:0]     op_i,
    input  logic [SHW-1:0] shamt_i,
    input  logic [SHW-1:0] scale_i,
    output logic [SHW-1:0] sh_amt_o,
    output logic           sel_imm_o,
    output logic           wr_res_o,
    output logic           wr_adr_o,
    output res_sel_e       res_sel_o
);
    always_comb begin
        sh_amt_o  = '0;
        sel_imm_o = 1'b0;
        wr_res_o  = 1'b0;
        wr_adr_o  = 1'b0;
        res_sel_o = RS_SUM;
        case (op_e'(op_i))
            OP_SHADD: begin
                sh_amt_o = shamt_i;
                wr_res_o = 1'b1;
            end
            OP_ADDI: begin
                sel_imm_o = 1'b1;
                wr_res_o  = 1'b1;
            end
            OP_AND: begin
                wr_res_o  = 1'b1;
                res_sel_o = RS_AND;
            end
            OP_OR: begin
                wr_res_o  = 1'b1;
                res_sel_o = RS_OR;
            end
            OP_LDX: begin
                sh_amt_o = scale_i;
                wr_adr_o = 1'b1;
            end
            OP_LDI: begin
                sel_imm_o = 1'b1;
                wr_adr_o  = 1'b1;
            end
            default: begin
                sh_amt_o = '0;
            end
        endcase
    end
endmodule

// File: rtl/ps_preshift.sv
module ps_preshift #(
    parameter int W   = 32,
    parameter int SHW = 2
) (
    input  logic [W-1:0]   val_i,
    input  logic [SHW-1:0] amt_i,
    output logic [W-1:0]   val_o
);
    logic [W-1:0] stage [0:SHW];

    assign stage[0] = val_i;

    for (genvar g = 0; g < SHW; g++) begin : g_stage
        localparam int STEP = 1 << g;
        assign stage[g+1] = amt_i[g] ? (stage[g] << STEP) : stage[g];
    end

    assign val_o = stage[SHW];

    // low bits vacated by the shift must be zero (R1)
    always_comb begin
        if (!$isunknown({val_o, amt_i})) begin
            assert_low_fill_R1: assert ((val_o & ((W'(1) << amt_i) - W'(1))) == '0)
                else $error("pre-shifter left nonzero low bits");
        end
    end
endmodule

// File: rtl/ps_immgen.sv
module ps_immgen #(
    parameter int IW = 16,
    parameter int W  = 32
) (
    input  logic [IW-1:0] imm_i,
    output logic [W-1:0]  imm_o
);
    localparam int EXT = W - IW;

    assign imm_o = {{EXT{imm_i[IW-1]}}, imm_i};
endmodule

// File: rtl/ps_adder.sv
module ps_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic         cy_o
);
    assign {cy_o, sum_o} = {1'b0, a_i} + {1'b0, b_i};
endmodule

// File: rtl/ps_exec_top.sv
module ps_exec_top
    import ps_pkg::*;
#(
    parameter int W   = 32,
    parameter int IW  = 16,
    parameter int SHW = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [2:0]     op_i,
    input  logic [W-1:0]   rs1_i,
    input  logic [W-1:0]   rs2_i,
    input  logic [IW-1:0]  imm_i,
    input  logic [SHW-1:0] shamt_i,
    input  logic [SHW-1:0] scale_i,
    output logic [W-1:0]   result_o,
    output logic           carry_o,
    output logic [W-1:0]   addr_o
);
    typedef struct packed {
        logic [W-1:0] res;
        logic         cy;
        logic [W-1:0] adr;
    } regs_t;

    regs_t          st_d, st_q;
    logic [SHW-1:0] sh_amt;
    logic           sel_imm, wr_res, wr_adr;
    res_sel_e       res_sel;
    logic [W-1:0]   shifted, imm_ext, add_b, sum;
    logic           sum_cy;

    ps_decode #(.SHW(SHW)) u_dec (
        .op_i      (op_i),
        .shamt_i   (shamt_i),
        .scale_i   (scale_i),
        .sh_amt_o  (sh_amt),
        .sel_imm_o (sel_imm),
        .wr_res_o  (wr_res),
        .wr_adr_o  (wr_adr),
        .res_sel_o (res_sel)
    );

    ps_preshift #(.W(W), .SHW(SHW)) u_shift (
        .val_i (rs2_i),
        .amt_i (sh_amt),
        .val_o (shifted)
    );

    ps_immgen #(.IW(IW), .W(W)) u_imm (
        .imm_i (imm_i),
        .imm_o (imm_ext)
    );

    assign add_b = sel_imm ? imm_ext : shifted;

    ps_adder #(.W(W)) u_add (
        .a_i   (rs1_i),
        .b_i   (add_b),
        .sum_o (sum),
        .cy_o  (sum_cy)
    );

    always_comb begin
        st_d = st_q;
        if (wr_res) begin
            case (res_sel)
                RS_AND:  begin st_d.res = rs1_i & rs2_i; st_d.cy = 1'b0; end
                RS_OR:   begin st_d.res = rs1_i | rs2_i; st_d.cy = 1'b0; end
                default: begin st_d.res = sum;           st_d.cy = sum_cy; end
            endcase
        end
        if (wr_adr) begin
            st_d.adr = sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.res;
    assign carry_o  = st_q.cy;
    assign addr_o   = st_q.adr;

    // only shift-and-add and indexed addressing may shift (R6, R7)
    assert_zero_shift_R7: assert property (@(posedge clk) disable iff (rst)
        !(op_i == OP_SHADD || op_i == OP_LDX) |-> sh_amt == '0)
        else $error("nonzero shift on an unscaled operation");

    assert_shadd_R1: assert property (@(posedge clk) disable iff (rst)
        op_i == OP_SHADD |=> result_o == $past(rs1_i + (rs2_i << shamt_i)))
        else $error("shift-and-add result mismatch");

    assert_hold_addr_R8: assert property (@(posedge clk) disable iff (rst)
        !(op_i == OP_LDX || op_i == OP_LDI) |=> $stable(addr_o))
        else $error("address changed on a non-address operation");

    assert_hold_res_R8: assert property (@(posedge clk) disable iff (rst)
        (op_i[2] == 1'b1) |=> ($stable(result_o) && $stable(carry_o)))
        else $error("result changed on an address or idle operation");

    assert_reset_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (result_o == '0 && addr_o == '0 && !carry_o))
        else $error("outputs not cleared by reset");
endmodule

// File: tb/test_ps_exec_top.sv
`timescale 1ns/1ps
module test_ps_exec_top;

    typedef struct {
        logic [31:0] res;
        logic        cy;
        logic [31:0] adr;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op = 3'b110;
    logic [31:0] rs1 = '0, rs2 = '0;
    logic [15:0] imm = '0;
    logic [1:0]  shamt = '0, scale = '0;
    logic [31:0] result, addr;
    logic        carry;

    exp_t        q[$];
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    logic [31:0] m_res = '0, m_adr = '0;
    logic        m_cy = 1'b0;

    always #2.5 clk = ~clk;

    ps_exec_top i_ps_exec_top (
        .clk      (clk),
        .rst      (rst),
        .op_i     (op),
        .rs1_i    (rs1),
        .rs2_i    (rs2),
        .imm_i    (imm),
        .shamt_i  (shamt),
        .scale_i  (scale),
        .result_o (result),
        .carry_o  (carry),
        .addr_o   (addr)
    );

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic push(input string req);
        exp_t e;
        e.res = m_res;
        e.cy  = m_cy;
        e.adr = m_adr;
        e.req = req;
        q.push_back(e);
    endtask

    task automatic do_reset(input string req);
        @(negedge clk);
        rst = 1'b1;
        m_res = '0; m_cy = 1'b0; m_adr = '0;
        push(req);
        @(negedge clk);
        rst = 1'b0;
        op = 3'b110;
        push(req);
    endtask

    task automatic drive(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic [1:0] sh, input logic [1:0] sc,
                         input string req);
        logic [32:0] s;
        logic [31:0] t;
        @(negedge clk);
        op = o; rs1 = a; rs2 = b; imm = im; shamt = sh; scale = sc;
        case (o)
            3'b000: begin t = b << sh; s = {1'b0, a} + {1'b0, t}; m_res = s[31:0]; m_cy = s[32]; end
            3'b001: begin s = {1'b0, a} + {1'b0, sx(im)}; m_res = s[31:0]; m_cy = s[32]; end
            3'b010: begin m_res = a & b; m_cy = 1'b0; end
            3'b011: begin m_res = a | b; m_cy = 1'b0; end
            3'b100: begin t = b << sc; m_adr = a + t; end
            3'b101: begin m_adr = a + sx(im); end
            default: ;
        endcase
        push(req);
    endtask

    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (result !== e.res || carry !== e.cy || addr !== e.adr) begin
                bad++;
                $display("FAIL %s: got res=%h cy=%b adr=%h, expected res=%h cy=%b adr=%h",
                         e.req, result, carry, addr, e.res, e.cy, e.adr);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset("R9 reset state");
        // R3: zero shift is a plain add
        drive(3'b000, 32'd5, 32'd7, 16'h0, 2'd0, 2'd3, "R3 shamt0 plain add");
        // R1: shift by 1, 2, 3, dropping high bits
        drive(3'b000, 32'd100, 32'd9, 16'h0, 2'd1, 2'd0, "R1 shift1");
        drive(3'b000, 32'h10, 32'h0000_0101, 16'h0, 2'd2, 2'd0, "R1 shift2");
        drive(3'b000, 32'd3, 32'h2000_0001, 16'h0, 2'd3, 2'd0, "R1 shift3 drop top bit");
        // R2: carry out of the add
        drive(3'b000, 32'hFFFF_FFFF, 32'd1, 16'h0, 2'd0, 2'd0, "R2 carry wrap");
        drive(3'b000, 32'h8000_0000, 32'h1000_0000, 16'h0, 2'd3, 2'd0, "R2 carry shifted");
        // R6: logic ops ignore shamt
        drive(3'b010, 32'hF0F0_1234, 32'h0FF0_FFFF, 16'h0, 2'd3, 2'd0, "R6 and unshifted");
        drive(3'b011, 32'h0000_00F0, 32'h0000_0003, 16'h0, 2'd2, 2'd0, "R6 or unshifted");
        // R7: add immediate, negative and positive, shamt ignored
        drive(3'b001, 32'd10, 32'hDEAD_BEEF, 16'hFFFE, 2'd3, 2'd0, "R7 addi negative");
        drive(3'b001, 32'hFFFF_FFF0, 32'd0, 16'h0020, 2'd2, 2'd0, "R7 addi carry");
        // R4: each index scale; R8: result held
        drive(3'b100, 32'h1000, 32'd5, 16'h0, 2'd0, 2'd0, "R4 scale byte");
        drive(3'b100, 32'h1000, 32'd5, 16'h0, 2'd0, 2'd1, "R4 scale half");
        drive(3'b100, 32'h1000, 32'd5, 16'h0, 2'd0, 2'd2, "R4 scale word");
        drive(3'b100, 32'h1000, 32'd5, 16'h0, 2'd3, 2'd3, "R4 scale dword");
        // R5: immediate offset, scale and rs2 ignored
        drive(3'b101, 32'h2000, 32'h7777, 16'h8000, 2'd0, 2'd3, "R5 ldi negative");
        drive(3'b101, 32'h2000, 32'h1, 16'h0040, 2'd1, 2'd2, "R5 ldi positive");
        // R8: idle codes hold all outputs
        drive(3'b110, 32'h1111_1111, 32'h2222_2222, 16'h1234, 2'd3, 2'd3, "R8 idle 110");
        drive(3'b111, 32'h3333_3333, 32'h4444_4444, 16'h4321, 2'd1, 2'd1, "R8 idle 111");
        // R8: arithmetic leaves address alone
        drive(3'b000, 32'd1, 32'd1, 16'h0, 2'd1, 2'd3, "R8 addr held on add");
        // R10: back-to-back operations, each due next edge
        drive(3'b000, 32'd0, 32'd1, 16'h0, 2'd3, 2'd0, "R10 back to back a");
        drive(3'b100, 32'd4, 32'd2, 16'h0, 2'd0, 2'd2, "R10 back to back b");
        drive(3'b011, 32'h5, 32'hA, 16'h0, 2'd0, 2'd0, "R10 back to back c");
        do_reset("R9 reset mid run");
        @(negedge clk);
        op = 3'b110;
        push("R9 held after reset");
        while (q.size() > 0) @(posedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule